// File: doc/BRIEF.md
# Byte-wide GPIO port with edge interrupts

This block provides eight general-purpose lines behind a small byte-wide register port. The lower four lines are fixed outputs driven from latches that software writes. The upper four lines are fixed inputs. Each input passes through a two-flop synchroniser, so software reads a stable level.

Each input can raise an interrupt on a rising edge, a falling edge, or either edge, or it can be masked. A captured edge sets a sticky status bit. A single active-high interrupt line stays asserted while any status bit is set. Software acknowledges events by writing ones to the status register, usually the same value it just read.

Register offsets: direction 0, data 1, edge configuration 3, status 4. Every other offset reads as zero.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the output latches, the edge configuration register and the status register are all 0, and `irq` is low.
- R2: Offset 0 always reads 0x0F, where a 1 marks an output line. Writes to offset 0 change nothing.
- R3: At offset 1, a write loads `bus_wdata[3:0]` into the output latches, which drive `pin_out`; `bus_wdata[7:4]` is discarded. A read returns the latches in bits 3:0 and the synchronised input levels in bits 7:4.
- R4: A change on `pin_in` shows in the offset-1 read data after two rising clock edges. An enabled edge sets its status bit on the third rising edge after the pin change.
- R5: Offset 3 is a read/write register. Input k (line 4+k) is controlled by bits [2k+1:2k]: the lower bit of the field enables falling-edge capture and the upper bit enables rising-edge capture.
- R6: When an input's field is 00, no edge on that input sets its status bit.
- R7: When an input's field is 11, both rising and falling edges set its status bit.
- R8: At offset 4, bit k is the sticky status of input k and bits 7:4 read as 0. Writing a 1 to bit k clears it. Writing a 0 leaves the bit unchanged.
- R9: If a new enabled edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly while at least one status bit is set, and stays high until every set bit has been cleared.
- R11: Offsets 2, 5, 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 4 | Input lines 4 to 7 (asynchronous) |
| pin_out | output | 4 | Output lines 0 to 3 |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The hardest case to reach from the ports is a clearing write that lands in the same cycle as a new edge on the same input. Reaching it needs two pin transitions one clock apart. The write is then timed against the three-register latency from pin to status. The stimulus first toggles an input configured for either edge, and toggles it back one cycle later. It then issues the acknowledge on exactly the clock where the second edge is captured, and reads the status to confirm that the bit survived.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   // Bit positions inside one per-input edge-select field
   localparam int unsigned SEL_FALL_BIT = 0;
   localparam int unsigned SEL_RISE_BIT = 1;
   localparam int unsigned SEL_W        = 2;

   typedef enum logic [SEL_W-1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_RISE = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell
   import gpio_edge_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             clr_i,
   output logic             stat_o
);

   logic prev_q;
   logic stat_q;
   logic rise;
   logic fall;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise = lvl_i & ~prev_q;
   assign fall = ~lvl_i & prev_q;
   assign hit  = (rise & sel_i[SEL_RISE_BIT]) | (fall & sel_i[SEL_FALL_BIT]);

   // A new capture takes priority over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= hit | (stat_q & ~clr_i);
   end

   assign stat_o = stat_q;

   // R6
   masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q) |-> $past(sel_i) != EDGE_OFF);

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit) |-> stat_q);

   // R8
   clear_only_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q) |-> $past(clr_i));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
   parameter int unsigned N_OUT    = 4,
   parameter int unsigned N_IN     = 4,
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 3,
   parameter int unsigned OFS_DIR  = 0,
   parameter int unsigned OFS_DATA = 1,
   parameter int unsigned OFS_CFG  = 3,
   parameter int unsigned OFS_STAT = 4,
   localparam int unsigned CFG_W   = 2 * N_IN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [N_IN-1:0]   in_lvl,
   input  logic [N_IN-1:0]   stat,
   output logic [N_OUT-1:0]  out_q,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [N_IN-1:0]   clr
);

   localparam logic [DW-1:0] DIR_VAL = {{N_IN{1'b0}}, {N_OUT{1'b1}}};

   logic wr_data;
   logic wr_cfg;
   logic wr_stat;

   assign wr_data = bus_wr && (bus_addr == AW'(OFS_DATA));
   assign wr_cfg  = bus_wr && (bus_addr == AW'(OFS_CFG));
   assign wr_stat = bus_wr && (bus_addr == AW'(OFS_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       out_q <= '0;
      else if (wr_data) out_q <= bus_wdata[N_OUT-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_cfg) cfg_q <= bus_wdata[CFG_W-1:0];
   end

   assign clr = wr_stat ? bus_wdata[N_IN-1:0] : '0;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(OFS_DIR))
         bus_rdata = DIR_VAL;
      else if (bus_addr == AW'(OFS_DATA))
         bus_rdata = {in_lvl, out_q};
      else if (bus_addr == AW'(OFS_CFG))
         bus_rdata[CFG_W-1:0] = cfg_q;
      else if (bus_addr == AW'(OFS_STAT))
         bus_rdata[N_IN-1:0] = stat;
   end

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr && bus_addr == AW'(OFS_DATA)) |-> $stable(out_q));

   // R5
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(bus_wr && bus_addr == AW'(OFS_CFG))
         |-> cfg_q == $past(bus_wdata[CFG_W-1:0]));

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int unsigned N_OUT       = 4,
   parameter int unsigned N_IN        = 4,
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OFS_DIR     = 0,
   parameter int unsigned OFS_DATA    = 1,
   parameter int unsigned OFS_CFG     = 3,
   parameter int unsigned OFS_STAT    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [N_IN-1:0]  pin_in,
   output logic [N_OUT-1:0] pin_out,
   output logic             irq
);

   localparam int unsigned CFG_W = SEL_W * N_IN;

   generate
      if (N_OUT + N_IN != DW) begin : g_bad_width
         $error("gpio_edge_port: N_OUT + N_IN must equal DW");
      end
      if (CFG_W > DW) begin : g_bad_cfg
         $error("gpio_edge_port: edge-select fields do not fit one register");
      end
      if ((1 << AW) <= OFS_STAT) begin : g_bad_addr
         $error("gpio_edge_port: AW too narrow for the register offsets");
      end
   endgenerate

   logic [N_IN-1:0]  in_lvl;
   logic [N_IN-1:0]  stat;
   logic [N_IN-1:0]  clr;
   logic [CFG_W-1:0] cfg_q;

   gpio_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_lvl)
   );

   gpio_regs #(
      .N_OUT    (N_OUT),
      .N_IN     (N_IN),
      .DW       (DW),
      .AW       (AW),
      .OFS_DIR  (OFS_DIR),
      .OFS_DATA (OFS_DATA),
      .OFS_CFG  (OFS_CFG),
      .OFS_STAT (OFS_STAT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .in_lvl    (in_lvl),
      .stat      (stat),
      .out_q     (pin_out),
      .cfg_q     (cfg_q),
      .clr       (clr)
   );

   for (genvar k = 0; k < N_IN; k++) begin : g_cell
      gpio_edge_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl_i  (in_lvl[k]),
         .sel_i  (cfg_q[SEL_W*k +: SEL_W]),
         .clr_i  (clr[k]),
         .stat_o (stat[k])
      );
   end

   assign irq = |stat;

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq) && !$past(bus_wr && bus_addr == AW'(OFS_STAT)) |-> irq);

endmodule

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] pin_in = '0;
   logic [3:0] pin_out;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   gpio_edge_port i_gpio_edge_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .irq       (irq)
   );

   // Row: chk[26] addr[25:23] data[22:15] pins[14:11] gap[10:9] irq[8] out[7:4] req[3:0]
   // Edge fields in 0x36: input0 rise, input1 fall, input2 either, input3 masked
   localparam int NROW = 28;
   localparam logic [26:0] TBL [NROW] = '{
      {1'b1, 3'd0, 8'h0F, 4'h0, 2'd0, 1'b0, 4'h0, 4'd2},  // R2 direction value
      {1'b0, 3'd0, 8'hFF, 4'h0, 2'd0, 1'b0, 4'h0, 4'd2},  // R2 write ignored
      {1'b1, 3'd0, 8'h0F, 4'h0, 2'd0, 1'b0, 4'h0, 4'd2},
      {1'b0, 3'd1, 8'hA5, 4'h0, 2'd0, 1'b0, 4'h0, 4'd3},  // R3 upper nibble discarded
      {1'b1, 3'd1, 8'h05, 4'h0, 2'd0, 1'b0, 4'h5, 4'd3},
      {1'b0, 3'd1, 8'h3A, 4'h0, 2'd0, 1'b0, 4'h0, 4'd3},
      {1'b1, 3'd1, 8'h0A, 4'h0, 2'd0, 1'b0, 4'hA, 4'd3},
      {1'b1, 3'd3, 8'h00, 4'h0, 2'd0, 1'b0, 4'hA, 4'd1},  // R1 config still zero
      {1'b1, 3'd1, 8'h0A, 4'hF, 2'd1, 1'b0, 4'hA, 4'd4},  // R4 one edge: not yet visible
      {1'b1, 3'd1, 8'hFA, 4'hF, 2'd1, 1'b0, 4'hA, 4'd4},  // R4 two edges: visible
      {1'b1, 3'd4, 8'h00, 4'hF, 2'd2, 1'b0, 4'hA, 4'd6},  // R6 all masked
      {1'b0, 3'd3, 8'h36, 4'hF, 2'd0, 1'b0, 4'h0, 4'd5},
      {1'b1, 3'd3, 8'h36, 4'hF, 2'd0, 1'b0, 4'hA, 4'd5},  // R5 readback
      {1'b1, 3'd4, 8'h00, 4'h0, 2'd2, 1'b0, 4'hA, 4'd4},  // R4 two edges after fall: no status
      {1'b1, 3'd4, 8'h06, 4'h0, 2'd1, 1'b1, 4'hA, 4'd7},  // R7 fall on inputs 1 and 2
      {1'b0, 3'd4, 8'h00, 4'h0, 2'd0, 1'b0, 4'h0, 4'd8},  // R8 zeros clear nothing
      {1'b1, 3'd4, 8'h06, 4'h0, 2'd0, 1'b1, 4'hA, 4'd8},
      {1'b0, 3'd4, 8'h02, 4'h0, 2'd0, 1'b0, 4'h0, 4'd8},
      {1'b1, 3'd4, 8'h04, 4'h0, 2'd0, 1'b1, 4'hA, 4'd10}, // R10 irq held by bit 2
      {1'b1, 3'd1, 8'h0A, 4'h0, 2'd0, 1'b1, 4'hA, 4'd3},
      {1'b1, 3'd4, 8'h05, 4'hF, 2'd3, 1'b1, 4'hA, 4'd7},  // R7 rise on inputs 0 and 2
      {1'b0, 3'd4, 8'hF5, 4'hF, 2'd0, 1'b0, 4'h0, 4'd8},
      {1'b1, 3'd4, 8'h00, 4'hF, 2'd0, 1'b0, 4'hA, 4'd10}, // R10 all cleared
      {1'b0, 3'd2, 8'hFF, 4'hF, 2'd0, 1'b0, 4'h0, 4'd11},
      {1'b1, 3'd2, 8'h00, 4'hF, 2'd0, 1'b0, 4'hA, 4'd11}, // R11 unused offsets
      {1'b1, 3'd5, 8'h00, 4'hF, 2'd0, 1'b0, 4'hA, 4'd11},
      {1'b1, 3'd7, 8'h00, 4'hF, 2'd0, 1'b0, 4'hA, 4'd11},
      {1'b1, 3'd1, 8'hFA, 4'hF, 2'd0, 1'b0, 4'hA, 4'd11}
   };

   task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic read_check(input int req, input logic [2:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      check(req, {8'h00, bus_rdata}, {8'h00, exp});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(1, {15'h0, irq}, 16'h0);
      check(1, {12'h0, pin_out}, 16'h0);
      read_check(1, 3'd1, 8'h00);
      read_check(1, 3'd3, 8'h00);
      read_check(1, 3'd4, 8'h00);

      for (int i = 0; i < NROW; i++) begin
         logic [26:0] r;
         r = TBL[i];
         pin_in = r[14:11];
         if (!r[26]) begin
            bus_write(r[25:23], r[22:15]);
         end else begin
            bus_addr = r[25:23];
            repeat (int'(r[10:9])) @(negedge clk);
            #1;
            check(int'(r[3:0]), {3'h0, r[8], r[7:4], r[22:15]},
                                {3'h0, irq, pin_out, bus_rdata});
         end
      end

      // R9 clear and new capture on input 2 in the same cycle
      @(negedge clk);
      pin_in = 4'hB;
      @(negedge clk);
      pin_in = 4'hF;
      @(negedge clk);
      @(negedge clk);
      bus_write(3'd4, 8'h04);
      read_check(9, 3'd4, 8'h04);
      check(9, {15'h0, irq}, 16'h1);
      bus_write(3'd4, 8'h04);
      read_check(8, 3'd4, 8'h00);

      // R1 reset in mid-run returns config and outputs to zero
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_check(1, 3'd3, 8'h00);
      check(1, {12'h0, pin_out}, 16'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule